// File: doc/BRIEF.md
# Watermark-Throttled Shared Issue Queue

This block sits between four warp-scheduler issue ports and a set of shared, slower execution pipes. In any cycle each scheduler may offer one instruction, tagged with a 3-bit target class. Address/branch, shared-memory, local/global and special-math work goes into a 16-entry shared queue. Texture work goes into a separate 8-entry queue. Per-partition math never enters either queue. It is accepted whenever that scheduler's own math unit is not busy. Because accepted instructions are buffered, a scheduler can offer an independent instruction on the very next cycle.

Each issue port follows valid/ready rules. `in_ready[p]` is a combinational answer to `in_valid[p]` in the same cycle. A refused instruction must be offered again unchanged until it is accepted. Each refusal carries a 3-bit throttle reason on `in_reason`. Local/global instructions are turned away early, once shared-queue occupancy reaches the runtime watermark `wm`. Other shared classes keep flowing until the queue is truly full. Both queues drain through valid/ready ports. While valid is high and ready is low, the head entry is held unchanged. Per-reason saturating counters report the stall totals.

Top module: `wm_issue_queue`

## Requirements
- R1: A synchronous active-low reset empties both queues (both drain valids low) and clears every stall counter to zero.
- R2: Classes 0 (address/branch), 1 (shared-memory), 2 (local/global) and 3 (special math) enter the shared queue. They drain in acceptance order with payload, class and port id. While `sq_out_valid` is high and `sq_out_ready` is low, the drain outputs stay stable.
- R3: The shared queue holds at most 16 entries. A shared-class instruction is refused with reason 1 when the queue holds 16 at the start of the cycle and no dequeue happens that cycle. If a dequeue happens in that cycle, the enqueue is accepted.
- R4: When `wm` is below 16 and start-of-cycle occupancy is at or above `wm`, a class-2 instruction is refused with reason 2. In the same situation, classes 0, 1 and 3 are still accepted while the queue is not full.
- R5: When `wm` equals 16, early throttling is off. Local/global instructions are accepted until the queue is full, and are then refused with reason 1.
- R6: Class 4 (texture) enters only the 8-entry texture queue and drains in order. It is refused with reason 3 when that queue holds 8 at the start of the cycle and no dequeue happens that cycle.
- R7: Class 5 (per-partition math) is accepted exactly when `math_busy[p]` is low and is refused with reason 4 otherwise. It never appears on either drain port.
- R8: At most one instruction per queue is accepted each cycle. The winner is the first eligible port at or after a round-robin pointer, which then moves to winner+1 modulo 4. After reset the pointer is 0. Eligible ports that lose are refused with reason 5. The two queues arbitrate independently.
- R9: `in_ready[p]` is never high without `in_valid[p]`. The reason is 0 whenever a port is idle or accepted.
- R10: The counter for reason k (1..5) sits at `stall_cnt[(k-1)*16 +: 16]`. Each cycle it adds the number of ports refused with reason k in that cycle, and it saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wm | input | 5 | Local/global watermark, 1..16 |
| in_valid | input | 4 | Per-port instruction valid |
| in_class | input | 12 | Per-port target class, 3 bits per port |
| in_payload | input | 64 | Per-port instruction payload, 16 bits per port |
| math_busy | input | 4 | Per-port partition math unit busy |
| in_ready | output | 4 | Per-port acceptance this cycle |
| in_reason | output | 12 | Per-port throttle reason, 3 bits per port |
| sq_out_valid | output | 1 | Shared queue head valid |
| sq_out_ready | input | 1 | Shared pipes take head |
| sq_out_payload | output | 16 | Shared head payload |
| sq_out_class | output | 3 | Shared head class |
| sq_out_port | output | 2 | Shared head source port |
| tq_out_valid | output | 1 | Texture queue head valid |
| tq_out_ready | input | 1 | Texture pipe takes head |
| tq_out_payload | output | 16 | Texture head payload |
| tq_out_port | output | 2 | Texture head source port |
| stall_cnt | output | 80 | Five saturating 16-bit stall counters |

## Verification
The hardest state to reach is a partly filled shared queue that sits above the watermark while local/global and shared-memory instructions arrive in the same cycle. The stimulus holds the drain ready low, pushes ordinary entries one at a time up to `wm`, and then offers both classes on different ports at once. A second hard case is the full queue with a simultaneous dequeue. To reach it, the queue is filled to 16 and then drain ready is raised in the same cycle as a new offer. Counter saturation needs tens of thousands of refusals. All four ports are held on busy partition math, which adds four counts per cycle.

// File: rtl/wiq_pkg.sv
package wiq_pkg;

  typedef enum logic [2:0] {
    CL_ADDR  = 3'd0,
    CL_SHM   = 3'd1,
    CL_LG    = 3'd2,
    CL_SFU   = 3'd3,
    CL_TEX   = 3'd4,
    CL_PMATH = 3'd5
  } iclass_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_SQ   = 3'd1,
    RS_LG   = 3'd2,
    RS_TEX  = 3'd3,
    RS_MATH = 3'd4,
    RS_ARB  = 3'd5
  } reason_e;

  localparam int NUM_REASON = 5;

  function automatic logic goes_shared(input logic [2:0] c);
    return (c != CL_TEX) && (c != CL_PMATH);
  endfunction

endpackage

// File: rtl/wiq_fifo.sv
module wiq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       nonempty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
    return (v == AW'(DEPTH-1)) ? '0 : v + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign dout     = mem[rd_ptr];
  assign nonempty = (count != '0);
endmodule

// File: rtl/wiq_rr_arb.sv
module wiq_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          any;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(ptr) + i;
      if (k >= N) k = k - N;
      if (!any && req[k]) begin
        any    = 1'b1;
        win    = IW'(k);
        gnt[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (any) ptr <= (win == IW'(N-1)) ? '0 : win + IW'(1);
  end
endmodule

// File: rtl/wiq_sat_cnt.sv
module wiq_sat_cnt #(
  parameter int W   = 16,
  parameter int NIN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] hit,
  output logic [W-1:0]   value
);
  logic [W:0] sum;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NIN; i++) n = n + int'(hit[i]);
    sum = {1'b0, value} + (W+1)'(n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (sum[W]) value <= '1;
    else             value <= sum[W-1:0];
  end
endmodule

// File: rtl/wm_issue_queue.sv
module wm_issue_queue
  import wiq_pkg::*;
#(
  parameter int NPORT    = 4,
  parameter int PW       = 16,
  parameter int SQ_DEPTH = 16,
  parameter int TQ_DEPTH = 8,
  parameter int CNT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SQ_DEPTH+1)-1:0] wm,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT*3-1:0]            in_class,
  input  logic [NPORT*PW-1:0]           in_payload,
  input  logic [NPORT-1:0]              math_busy,
  output logic [NPORT-1:0]              in_ready,
  output logic [NPORT*3-1:0]            in_reason,
  output logic                          sq_out_valid,
  input  logic                          sq_out_ready,
  output logic [PW-1:0]                 sq_out_payload,
  output logic [2:0]                    sq_out_class,
  output logic [$clog2(NPORT)-1:0]      sq_out_port,
  output logic                          tq_out_valid,
  input  logic                          tq_out_ready,
  output logic [PW-1:0]                 tq_out_payload,
  output logic [$clog2(NPORT)-1:0]      tq_out_port,
  output logic [NUM_REASON*CNT_W-1:0]   stall_cnt
);
  localparam int CW = $clog2(SQ_DEPTH+1);
  localparam int TW = $clog2(TQ_DEPTH+1);
  localparam int IW = $clog2(NPORT);
  localparam int EW = 3 + IW + PW;

  logic [CW-1:0] sq_cnt;
  logic [TW-1:0] tq_cnt;
  logic sq_deq, tq_deq, sq_blk, tq_blk, lg_early;
  logic [NPORT-1:0] sq_req, tq_req, sq_gnt, tq_gnt, math_ok;
  logic [NPORT*3-1:0] blk_rsn;
  logic [EW-1:0] sq_din, tq_din, sq_dout, tq_dout;
  logic [2:0] tq_cls_unused;

  assign sq_deq   = sq_out_valid && sq_out_ready;
  assign tq_deq   = tq_out_valid && tq_out_ready;
  assign sq_blk   = (sq_cnt == CW'(SQ_DEPTH)) && !sq_deq;
  assign tq_blk   = (tq_cnt == TW'(TQ_DEPTH)) && !tq_deq;
  assign lg_early = (wm < CW'(SQ_DEPTH)) && (sq_cnt >= wm);

  // Per-port classification into queue requests or immediate refusals
  always_comb begin
    sq_req  = '0;
    tq_req  = '0;
    math_ok = '0;
    blk_rsn = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic [2:0] c;
      c = in_class[p*3 +: 3];
      if (in_valid[p]) begin
        if (c == CL_PMATH) begin
          if (math_busy[p]) blk_rsn[p*3 +: 3] = RS_MATH;
          else              math_ok[p] = 1'b1;
        end else if (c == CL_TEX) begin
          if (tq_blk) blk_rsn[p*3 +: 3] = RS_TEX;
          else        tq_req[p] = 1'b1;
        end else if (c == CL_LG && lg_early) begin
          blk_rsn[p*3 +: 3] = RS_LG;
        end else if (sq_blk) begin
          blk_rsn[p*3 +: 3] = RS_SQ;
        end else begin
          sq_req[p] = 1'b1;
        end
      end
    end
  end

  wiq_rr_arb #(.N(NPORT)) u_sq_arb (
    .clk(clk), .rst_n(rst_n), .req(sq_req), .gnt(sq_gnt)
  );
  wiq_rr_arb #(.N(NPORT)) u_tq_arb (
    .clk(clk), .rst_n(rst_n), .req(tq_req), .gnt(tq_gnt)
  );

  // Ready, reason and winner entry selection
  always_comb begin
    sq_din = '0;
    tq_din = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic [EW-1:0] ent;
      ent = {in_class[p*3 +: 3], IW'(p), in_payload[p*PW +: PW]};
      in_ready[p] = sq_gnt[p] || tq_gnt[p] || math_ok[p];
      if ((sq_req[p] && !sq_gnt[p]) || (tq_req[p] && !tq_gnt[p]))
        in_reason[p*3 +: 3] = RS_ARB;
      else
        in_reason[p*3 +: 3] = blk_rsn[p*3 +: 3];
      if (sq_gnt[p]) sq_din = ent;
      if (tq_gnt[p]) tq_din = ent;
    end
  end

  wiq_fifo #(.DEPTH(SQ_DEPTH), .W(EW)) u_sq (
    .clk(clk), .rst_n(rst_n), .push(|sq_gnt), .din(sq_din), .pop(sq_deq),
    .dout(sq_dout), .nonempty(sq_out_valid), .count(sq_cnt)
  );
  wiq_fifo #(.DEPTH(TQ_DEPTH), .W(EW)) u_tq (
    .clk(clk), .rst_n(rst_n), .push(|tq_gnt), .din(tq_din), .pop(tq_deq),
    .dout(tq_dout), .nonempty(tq_out_valid), .count(tq_cnt)
  );

  assign {sq_out_class, sq_out_port, sq_out_payload} = sq_dout;
  assign {tq_cls_unused, tq_out_port, tq_out_payload} = tq_dout;

  for (genvar r = 0; r < NUM_REASON; r++) begin : g_cnt
    logic [NPORT-1:0] hit;
    for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hit[p] = (in_reason[p*3 +: 3] == 3'(r + 1));
    end
    wiq_sat_cnt #(.W(CNT_W), .NIN(NPORT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(hit), .value(stall_cnt[r*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/wiq_checker.sv
module wiq_checker #(
  parameter int NPORT    = 4,
  parameter int SQ_DEPTH = 16,
  parameter int TQ_DEPTH = 8,
  parameter int PW       = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [$clog2(SQ_DEPTH+1)-1:0] wm,
  input logic [NPORT-1:0]              in_valid,
  input logic [NPORT*3-1:0]            in_class,
  input logic [NPORT-1:0]              math_busy,
  input logic [NPORT-1:0]              in_ready,
  input logic [NPORT*3-1:0]            in_reason,
  input logic [$clog2(SQ_DEPTH+1)-1:0] sq_cnt,
  input logic [$clog2(TQ_DEPTH+1)-1:0] tq_cnt,
  input logic                          sq_out_valid,
  input logic                          sq_out_ready,
  input logic [PW-1:0]                 sq_out_payload
);
  localparam int CW = $clog2(SQ_DEPTH+1);
  localparam int TW = $clog2(TQ_DEPTH+1);

  logic [NPORT-1:0] shared_mask, tex_mask;
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic [2:0] c;
      c = in_class[p*3 +: 3];
      shared_mask[p] = (c != 3'd4) && (c != 3'd5);
      tex_mask[p]    = (c == 3'd4);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sq_cnt <= CW'(SQ_DEPTH)) else $error("shared queue overflow");

  p_tex_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tq_cnt <= TW'(TQ_DEPTH)) else $error("texture queue overflow");

  p_drain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sq_out_valid && !sq_out_ready |=> sq_out_valid && $stable(sq_out_payload))
    else $error("drain head changed under back-pressure");

  p_one_enq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_ready & in_valid & shared_mask) <= 1 &&
    $countones(in_ready & in_valid & tex_mask) <= 1)
    else $error("more than one enqueue per queue");

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0) else $error("ready without valid");

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    p_lg_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[p] && in_class[p*3 +: 3] == 3'd2 && wm < CW'(SQ_DEPTH) && sq_cnt >= wm
      |-> !in_ready[p] && in_reason[p*3 +: 3] == 3'd2)
      else $error("local/global not throttled at watermark");

    p_math_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[p] && in_class[p*3 +: 3] == 3'd5
      |-> (in_ready[p] == !math_busy[p]) &&
          (in_reason[p*3 +: 3] == (math_busy[p] ? 3'd4 : 3'd0)))
      else $error("partition math handling wrong");
  end
endmodule

bind wm_issue_queue wiq_checker #(
  .NPORT(NPORT), .SQ_DEPTH(SQ_DEPTH), .TQ_DEPTH(TQ_DEPTH), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wm(wm), .in_valid(in_valid), .in_class(in_class),
  .math_busy(math_busy), .in_ready(in_ready), .in_reason(in_reason),
  .sq_cnt(sq_cnt), .tq_cnt(tq_cnt), .sq_out_valid(sq_out_valid),
  .sq_out_ready(sq_out_ready), .sq_out_payload(sq_out_payload)
);

// File: tb/wm_issue_queue_tb.sv
module wm_issue_queue_tb;
  localparam int NP = 4;
  localparam int PW = 16;
  localparam int CWD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] wm = 5'd16;
  logic [NP-1:0] in_valid = '0;
  logic [NP*3-1:0] in_class = '0;
  logic [NP*PW-1:0] in_payload = '0;
  logic [NP-1:0] math_busy = '0;
  logic [NP-1:0] in_ready;
  logic [NP*3-1:0] in_reason;
  logic sq_out_valid, tq_out_valid;
  logic sq_out_ready = 1'b0, tq_out_ready = 1'b0;
  logic [PW-1:0] sq_out_payload, tq_out_payload;
  logic [2:0] sq_out_class;
  logic [1:0] sq_out_port, tq_out_port;
  logic [5*CWD-1:0] stall_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  wm_issue_queue u_dut (
    .clk(clk), .rst_n(rst_n), .wm(wm), .in_valid(in_valid), .in_class(in_class),
    .in_payload(in_payload), .math_busy(math_busy), .in_ready(in_ready),
    .in_reason(in_reason), .sq_out_valid(sq_out_valid), .sq_out_ready(sq_out_ready),
    .sq_out_payload(sq_out_payload), .sq_out_class(sq_out_class),
    .sq_out_port(sq_out_port), .tq_out_valid(tq_out_valid),
    .tq_out_ready(tq_out_ready), .tq_out_payload(tq_out_payload),
    .tq_out_port(tq_out_port), .stall_cnt(stall_cnt)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0;
    in_class = '0;
    in_payload = '0;
  endtask

  task automatic offer(input int p, input int cls, input int pay);
    in_valid[p] = 1'b1;
    in_class[p*3 +: 3] = 3'(cls);
    in_payload[p*PW +: PW] = PW'(pay);
  endtask

  function automatic int rsn(input int p);
    return int'(in_reason[p*3 +: 3]);
  endfunction

  function automatic int cnt(input int k);
    return int'(stall_cnt[(k-1)*CWD +: CWD]);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    sq_out_ready = 1'b0;
    tq_out_ready = 1'b0;
    math_busy = '0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  // Push one instruction alone on a port, checking it is taken
  task automatic push_ok(input string req, input int p, input int cls, input int pay);
    idle();
    offer(p, cls, pay);
    #1;
    chk(req, int'(in_ready[p]), 1);
    step();
    idle();
  endtask

  task automatic drain_sq(input string req, input int exp_q[$]);
    idle();
    sq_out_ready = 1'b1;
    foreach (exp_q[i]) begin
      #1;
      chk(req, int'(sq_out_valid), 1);
      chk(req, int'(sq_out_payload), exp_q[i]);
      step();
    end
    #1;
    chk(req, int'(sq_out_valid), 0);
    sq_out_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 sq empty", int'(sq_out_valid), 0);
    chk("R1 tq empty", int'(tq_out_valid), 0);
    for (int k = 1; k <= 5; k++) chk("R1 counter clear", cnt(k), 0);
  endtask

  task automatic t_fill_swap();
    int q[$];
    wm = 5'd16;
    for (int i = 0; i < 16; i++) push_ok("R2 shared accept", 0, 0, i);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2 head held", int'(sq_out_payload), 0);
      chk("R2 class", int'(sq_out_class), 0);
      step();
    end
    offer(0, 0, 77);
    offer(1, 2, 78);
    #1;
    chk("R3 full refused", int'(in_ready[0]), 0);
    chk("R3 full reason", rsn(0), 1);
    chk("R5 lg at full wm16", rsn(1), 1);
    step();
    idle();
    offer(0, 1, 99);
    sq_out_ready = 1'b1;
    #1;
    chk("R3 full with dequeue accepted", int'(in_ready[0]), 1);
    step();
    sq_out_ready = 1'b0;
    offer(0, 1, 100);
    #1;
    chk("R3 still full", rsn(0), 1);
    idle();
    for (int i = 1; i < 16; i++) q.push_back(i);
    q.push_back(99);
    drain_sq("R2 order", q);
  endtask

  task automatic t_watermark();
    int q[$];
    wm = 5'd4;
    for (int i = 0; i < 3; i++) push_ok("R4 below wm", 0, 1, 10 + i);
    push_ok("R4 lg at occupancy 3", 0, 2, 13);
    offer(0, 2, 14);
    offer(1, 1, 15);
    #1;
    chk("R4 lg throttled", rsn(0), 2);
    chk("R4 lg not ready", int'(in_ready[0]), 0);
    chk("R4 shm still accepted", int'(in_ready[1]), 1);
    step();
    idle();
    offer(2, 3, 16);
    #1;
    chk("R4 sfu above wm", int'(in_ready[2]), 1);
    step();
    idle();
    q = '{10, 11, 12, 13, 15, 16};
    drain_sq("R4 contents", q);
    push_ok("R4 lg after drain", 0, 2, 20);
    q = '{20};
    drain_sq("R4 drain", q);
  endtask

  task automatic t_wm16();
    int q[$];
    wm = 5'd16;
    for (int i = 0; i < 16; i++) begin
      push_ok("R5 lg accepted no early throttle", 3, 2, 200 + i);
      q.push_back(200 + i);
    end
    offer(3, 2, 250);
    #1;
    chk("R5 lg refused at full", rsn(3), 1);
    idle();
    drain_sq("R5 drain", q);
  endtask

  task automatic t_tex();
    for (int i = 0; i < 8; i++) push_ok("R6 tex accept", 2, 4, 300 + i);
    #1;
    chk("R6 not in shared", int'(sq_out_valid), 0);
    offer(2, 4, 400);
    #1;
    chk("R6 tex full reason", rsn(2), 3);
    idle();
    tq_out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R6 tex order", int'(tq_out_payload), 300 + i);
      chk("R6 tex port", int'(tq_out_port), 2);
      step();
    end
    #1;
    chk("R6 tex empty", int'(tq_out_valid), 0);
    tq_out_ready = 1'b0;
  endtask

  task automatic t_math();
    offer(3, 5, 1);
    math_busy = 4'b0000;
    #1;
    chk("R7 math free ready", int'(in_ready[3]), 1);
    chk("R7 math free reason", rsn(3), 0);
    step();
    math_busy = 4'b1000;
    #1;
    chk("R7 math busy reason", rsn(3), 4);
    chk("R7 math busy ready", int'(in_ready[3]), 0);
    step();
    idle();
    math_busy = '0;
    #1;
    chk("R7 no shared entry", int'(sq_out_valid), 0);
    chk("R7 no tex entry", int'(tq_out_valid), 0);
  endtask

  task automatic t_idle();
    idle();
    #1;
    chk("R9 idle ready", int'(in_ready), 0);
    chk("R9 idle reason", int'(in_reason), 0);
  endtask

  task automatic t_rr();
    int q[$];
    do_reset();
    wm = 5'd16;
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 4; p++) offer(p, 0, p);
      #1;
      chk("R8 rr grant", int'(in_ready), 1 << i);
      for (int p = 0; p < 4; p++)
        if (p != i) chk("R8 loser reason", rsn(p), 5);
      step();
    end
    idle();
    offer(1, 1, 1);
    offer(3, 1, 3);
    #1;
    chk("R8 ptr wrap to 1", int'(in_ready), 4'b0010);
    step();
    #1;
    chk("R8 next is 3", int'(in_ready), 4'b1000);
    step();
    #1;
    chk("R8 back to 1", int'(in_ready), 4'b0010);
    step();
    idle();
    offer(0, 4, 500);
    offer(1, 1, 1);
    #1;
    chk("R8 independent queues", int'(in_ready), 4'b0011);
    step();
    idle();
    #1;
    chk("R10 arbitration count", cnt(5), 15);
    chk("R10 other count", cnt(1), 0);
    q = '{0, 1, 2, 3, 1, 3, 1, 1};
    drain_sq("R8 order", q);
    tq_out_ready = 1'b1;
    #1;
    chk("R8 tex winner", int'(tq_out_payload), 500);
    step();
    tq_out_ready = 1'b0;
  endtask

  task automatic t_counters();
    do_reset();
    math_busy = 4'b1111;
    for (int p = 0; p < 4; p++) offer(p, 5, p);
    for (int i = 0; i < 10; i++) step();
    #1;
    chk("R10 math count", cnt(4), 40);
    chk("R10 lg count", cnt(2), 0);
    for (int i = 0; i < 16384; i++) step();
    #1;
    chk("R10 saturate", cnt(4), 65535);
    step();
    #1;
    chk("R10 stays saturated", cnt(4), 65535);
    idle();
    math_busy = '0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_fill_swap();
    t_watermark();
    t_wm16();
    t_tex();
    t_math();
    t_rr();
    t_counters();
    summary();
  end
endmodule